// File: doc/BRIEF.md
# Four-Level Symbol Group Framer With Two-Level Marker

This block puts a 17-bit coded word (16 data bits plus one carry bit) onto a symbol line and takes it back off. On the send side, each word becomes a group of nine 2-bit level codes. Eight of them are four-level symbols carrying the data. The ninth is a two-level symbol carrying the carry. A flag beside each outgoing symbol tells the line driver which symbols are two-level. The send side takes a new word every nine cycles and signals the cycle in which it samples the word.

On the receive side, the block runs a slot counter over the incoming symbols. It judges the symbol in the marker slot: a two-level symbol may only use the outer codes, so an inner code there is a marker violation. After enough consecutive good markers the block declares alignment and starts delivering words. While aligned, a bad marker is flagged like a transmission error. A short run of bad markers drops alignment. While unaligned, each bad marker moves the slot by one symbol, so the hunt walks through every possible phase of the group.

The marker position, before or after the data, is a build-time parameter. So are the lock and unlock run lengths.

Top module: `symframer`

## Requirements
- R1: The send side emits one symbol per cycle in groups of nine. `tx_take` is high in exactly one cycle of every nine. The word is sampled in that cycle. The first symbol of the group appears on `tx_sym` in the next cycle. The marker is the first symbol of the group when MARK_FIRST=1 and the last symbol when MARK_FIRST=0.
- R2: The eight data symbols carry the data word two bits at a time, most significant pair first (bits 15:14 first, bits 1:0 last). Each data symbol is sent with `tx_two`=0.
- R3: The marker symbol is 2'b11 when the carry is 1 and 2'b00 when the carry is 0. It is sent with `tx_two`=1.
- R4: After reset, `tx_sym`=0, `tx_two`=0, `rx_locked`=0, `rx_word_vld`=0 and `rx_err`=0. The receive slot counter starts with the next received symbol taken as group position 0.
- R5: A received marker is valid when it is 2'b00 or 2'b11. `rx_locked` rises one cycle after the fourth consecutive valid marker in the same slot, and not earlier.
- R6: While locked, the block delivers each group: the cycle after the last symbol of the group, `rx_word_vld` pulses for one cycle with `rx_word` and `rx_carry` (carry = upper bit of the marker). No word is delivered while unlocked.
- R7: While locked, a marker of 2'b01 or 2'b10 makes `rx_err` pulse for one cycle, one cycle after that marker. A single such marker keeps the lock, and the group's word is still delivered.
- R8: While locked, a valid marker clears the run of violations. The lock drops at the third consecutive violation, and that violation also raises `rx_err`.
- R9: While unlocked, a marker violation clears the count of good markers. It also shifts the slot by one symbol, so the next received symbol is judged as the marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one symbol per cycle each way |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_word | input | 16 | Data word to send |
| tx_carry | input | 1 | Carry bit to send in the marker |
| tx_take | output | 1 | High in the cycle the word and carry are sampled |
| tx_sym | output | 2 | Outgoing level code |
| tx_two | output | 1 | Outgoing symbol is two-level (marker) |
| rx_sym | input | 2 | Incoming level code |
| rx_locked | output | 1 | Group alignment found |
| rx_word_vld | output | 1 | One-cycle pulse: recovered word valid |
| rx_word | output | 16 | Recovered data word |
| rx_carry | output | 1 | Recovered carry bit |
| rx_err | output | 1 | One-cycle pulse: marker violation while locked |

## Verification
The bench builds the block with the marker ahead of the data (MARK_FIRST=1), a lock run of 4 and an unlock run of 3. With the marker first, an error pulse arrives eight symbols before the word of its group, which tests that the two are kept apart. The short runs allow several tests in a short time. One test is a false marker on a data symbol that sits in the hunted slot. Another is a relock after three violations, where the rest of the group is all inner levels, so the slot walks symbol by symbol back to the true marker.

// File: rtl/framer_pkg.sv
package framer_pkg;
    localparam int SYM_W = 2;
    typedef logic [SYM_W-1:0] sym_t;

    // Outer levels only are legal for a two-level symbol.
    function automatic logic outer_level(input sym_t s);
        return (s == 2'b00) || (s == 2'b11);
    endfunction
endpackage

// File: rtl/sym_tx_ser.sv
module sym_tx_ser
    import framer_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter bit MARK_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] word_i,
    input  logic              carry_i,
    output logic              take_o,
    output sym_t              sym_o,
    output logic              two_o
);
    localparam int NDATA = DATA_W / SYM_W;
    localparam int GRP   = NDATA + 1;
    localparam int POS_W = $clog2(GRP);
    localparam logic [POS_W-1:0] MPOS = MARK_FIRST ? '0 : POS_W'(GRP - 1);
    localparam logic [POS_W-1:0] LAST = POS_W'(GRP - 1);

    typedef struct packed {
        logic [POS_W-1:0]  slot;
        logic [DATA_W-1:0] word;
        logic              carry;
        sym_t              sym;
        logic              two;
    } tx_st_t;

    tx_st_t q, d;

    always_comb begin
        logic [DATA_W-1:0] src_w;
        logic              src_c;
        logic [POS_W-1:0]  idx;
        logic [DATA_W-1:0] shifted;
        d       = q;
        take_o  = (q.slot == '0);
        src_w   = take_o ? word_i  : q.word;
        src_c   = take_o ? carry_i : q.carry;
        d.word  = src_w;
        d.carry = src_c;
        idx     = MARK_FIRST ? (q.slot - POS_W'(1)) : q.slot;
        shifted = src_w << {idx, 1'b0};
        if (q.slot == MPOS) begin
            d.sym = {SYM_W{src_c}};
            d.two = 1'b1;
        end else begin
            d.sym = shifted[DATA_W-1 -: SYM_W];
            d.two = 1'b0;
        end
        d.slot = (q.slot == LAST) ? '0 : q.slot + POS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sym_o = q.sym;
    assign two_o = q.two;

    p_take_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (two_o == MARK_FIRST));
    p_marker_outer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        two_o |-> outer_level(sym_o));
    p_take_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);
endmodule

// File: rtl/sym_rx_align.sv
module sym_rx_align
    import framer_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter bit MARK_FIRST = 1'b1,
    parameter int LOCK_N     = 4,
    parameter int UNLOCK_N   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sym_t              sym_i,
    output logic              locked_o,
    output logic              vld_o,
    output logic [DATA_W-1:0] word_o,
    output logic              carry_o,
    output logic              err_o
);
    localparam int NDATA = DATA_W / SYM_W;
    localparam int GRP   = NDATA + 1;
    localparam int POS_W = $clog2(GRP);
    localparam int RUN_M = (LOCK_N > UNLOCK_N) ? LOCK_N : UNLOCK_N;
    localparam int CW    = $clog2(RUN_M + 1);
    localparam logic [POS_W-1:0] MPOS = MARK_FIRST ? '0 : POS_W'(GRP - 1);
    localparam logic [POS_W-1:0] LAST = POS_W'(GRP - 1);

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [DATA_W-1:0] data;
        logic              carry;
        logic              locked;
        logic [CW-1:0]     good;
        logic [CW-1:0]     bad;
        logic              vld;
        logic [DATA_W-1:0] word;
        logic              wcarry;
        logic              err;
    } rx_st_t;

    rx_st_t q, d;
    logic   at_mark, mark_ok, slip;

    always_comb begin
        d       = q;
        d.vld   = 1'b0;
        d.err   = 1'b0;
        slip    = 1'b0;
        at_mark = (q.pos == MPOS);
        mark_ok = outer_level(sym_i);
        if (at_mark) begin
            d.carry = sym_i[SYM_W-1];
            if (mark_ok) begin
                if (q.locked) begin
                    d.bad = '0;
                end else if (q.good == CW'(LOCK_N - 1)) begin
                    d.locked = 1'b1;
                    d.good   = '0;
                end else begin
                    d.good = q.good + CW'(1);
                end
            end else if (q.locked) begin
                d.err = 1'b1;
                if (q.bad == CW'(UNLOCK_N - 1)) begin
                    d.locked = 1'b0;
                    d.bad    = '0;
                    slip     = 1'b1;
                end else begin
                    d.bad = q.bad + CW'(1);
                end
            end else begin
                d.good = '0;
                slip   = 1'b1;
            end
        end else begin
            d.data = {q.data[DATA_W-SYM_W-1:0], sym_i};
        end
        if (!slip) d.pos = (q.pos == LAST) ? '0 : q.pos + POS_W'(1);
        if (q.pos == LAST && d.locked) begin
            d.vld    = 1'b1;
            d.word   = MARK_FIRST ? {q.data[DATA_W-SYM_W-1:0], sym_i} : q.data;
            d.wcarry = MARK_FIRST ? q.carry : sym_i[SYM_W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign locked_o = q.locked;
    assign vld_o    = q.vld;
    assign word_o   = q.word;
    assign carry_o  = q.wcarry;
    assign err_o    = q.err;

    p_word_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> locked_o);
    p_lock_after_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> ($past(q.good) == CW'(LOCK_N - 1) && $past(at_mark)));
    p_err_on_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked_o) |-> err_o);
    p_err_needs_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(locked_o));
    p_slip_holds_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_o && at_mark && !mark_ok) |=> (q.pos == $past(q.pos)));
endmodule

// File: rtl/symframer.sv
module symframer
    import framer_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter bit MARK_FIRST = 1'b1,
    parameter int LOCK_N     = 4,
    parameter int UNLOCK_N   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_carry,
    output logic              tx_take,
    output logic [1:0]        tx_sym,
    output logic              tx_two,
    input  logic [1:0]        rx_sym,
    output logic              rx_locked,
    output logic              rx_word_vld,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_carry,
    output logic              rx_err
);
    sym_tx_ser #(.DATA_W(DATA_W), .MARK_FIRST(MARK_FIRST)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_i  (tx_word),
        .carry_i (tx_carry),
        .take_o  (tx_take),
        .sym_o   (tx_sym),
        .two_o   (tx_two)
    );

    sym_rx_align #(.DATA_W(DATA_W), .MARK_FIRST(MARK_FIRST),
                   .LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_i    (rx_sym),
        .locked_o (rx_locked),
        .vld_o    (rx_word_vld),
        .word_o   (rx_word),
        .carry_o  (rx_carry),
        .err_o    (rx_err)
    );
endmodule

// File: tb/symframer_tb.sv
module symframer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tx_word = '0;
    logic        tx_carry = 1'b0;
    logic        tx_take, tx_two;
    logic [1:0]  tx_sym;
    logic [1:0]  rx_sym = 2'b01;
    logic        rx_locked, rx_word_vld, rx_carry, rx_err;
    logic [15:0] rx_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    symframer #(.DATA_W(16), .MARK_FIRST(1'b1), .LOCK_N(4), .UNLOCK_N(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .tx_carry(tx_carry),
        .tx_take(tx_take), .tx_sym(tx_sym), .tx_two(tx_two), .rx_sym(rx_sym),
        .rx_locked(rx_locked), .rx_word_vld(rx_word_vld), .rx_word(rx_word),
        .rx_carry(rx_carry), .rx_err(rx_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic put(input logic [1:0] s);
        rx_sym = s;
        @(negedge clk);
    endtask

    // Sends marker then 8 data symbols; reports observations.
    task automatic rx_group(input logic [15:0] w, input logic [1:0] msym,
                            output logic lk_m, output logic err_m,
                            output int nvld, output logic [15:0] gw, output logic gc);
        nvld = 0;
        put(msym);
        lk_m  = rx_locked;
        err_m = rx_err;
        for (int i = 0; i < 8; i++) begin
            put(w[15-2*i -: 2]);
            if (rx_word_vld) nvld++;
        end
        gw = rx_word;
        gc = rx_carry;
    endtask

    task automatic t_reset();
        do_reset();
        check("R4 tx_sym", 32'(tx_sym), 0);
        check("R4 tx_two", 32'(tx_two), 0);
        check("R4 rx_locked", 32'(rx_locked), 0);
        check("R4 rx_word_vld", 32'(rx_word_vld), 0);
        check("R4 rx_err", 32'(rx_err), 0);
    endtask

    task automatic tx_one(input logic [15:0] w, input logic c);
        int takes;
        tx_word  = w;
        tx_carry = c;
        while (!tx_take) @(negedge clk);
        takes = 0;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            if (k < 8 && tx_take) takes++;
            if (k == 0) begin
                check("R3 marker sym", 32'(tx_sym), c ? 3 : 0);
                check("R3 marker flag", 32'(tx_two), 1);
            end else begin
                check("R2 data sym", 32'(tx_sym), 32'(w[15-2*(k-1) -: 2]));
                check("R2 data flag", 32'(tx_two), 0);
            end
        end
        check("R1 take spacing", 32'(takes), 0);
        check("R1 take at group end", 32'(tx_take), 1);
    endtask

    task automatic t_tx();
        tx_one(16'hE41B, 1'b1);
        tx_one(16'h1B72, 1'b0);
    endtask

    task automatic t_acquire();
        logic lk, er, gc; int nv; logic [15:0] gw;
        do_reset();
        for (int g = 0; g < 3; g++) begin
            rx_group(16'h1234 + 16'(g), 2'b11, lk, er, nv, gw, gc);
            check("R5 no early lock", 32'(lk), 0);
            check("R6 no word unlocked", 32'(nv), 0);
        end
        rx_group(16'hA5C3, 2'b11, lk, er, nv, gw, gc);
        check("R5 lock on 4th", 32'(lk), 1);
        check("R6 word count", 32'(nv), 1);
        check("R6 word", 32'(gw), 32'h A5C3);
        check("R6 carry 1", 32'(gc), 1);
        rx_group(16'h0F96, 2'b00, lk, er, nv, gw, gc);
        check("R6 word b", 32'(gw), 32'h0F96);
        check("R6 carry 0", 32'(gc), 0);
    endtask

    task automatic t_single_err();
        logic lk, er, gc; int nv; logic [15:0] gw;
        rx_group(16'h3C5A, 2'b01, lk, er, nv, gw, gc);
        check("R7 err pulse", 32'(er), 1);
        check("R7 lock held", 32'(lk), 1);
        check("R7 word still out", 32'(gw), 32'h3C5A);
        check("R7 err one cycle", 32'(rx_err), 0);
        rx_group(16'h6B21, 2'b11, lk, er, nv, gw, gc);
        check("R7 no err good", 32'(er), 0);
    endtask

    task automatic t_drop_relock();
        logic lk, er, gc; int nv; logic [15:0] gw;
        rx_group(16'h1111, 2'b10, lk, er, nv, gw, gc);
        rx_group(16'h2222, 2'b01, lk, er, nv, gw, gc);
        check("R8 two bad still locked", 32'(lk), 1);
        rx_group(16'h3333, 2'b00, lk, er, nv, gw, gc);
        rx_group(16'h4444, 2'b01, lk, er, nv, gw, gc);
        rx_group(16'h5555, 2'b10, lk, er, nv, gw, gc);
        check("R8 run cleared", 32'(lk), 1);
        check("R8 word with err", 32'(nv), 1);
        rx_group(16'h5555, 2'b01, lk, er, nv, gw, gc);
        check("R8 drop at 3rd", 32'(lk), 0);
        check("R8 err on drop", 32'(er), 1);
        check("R8 no word after drop", 32'(nv), 0);
        for (int g = 0; g < 3; g++) begin
            rx_group(16'h9876, 2'b00, lk, er, nv, gw, gc);
            check("R9 relock wait", 32'(lk), 0);
        end
        rx_group(16'hC3E1, 2'b11, lk, er, nv, gw, gc);
        check("R9 relock", 32'(lk), 1);
        check("R9 relock word", 32'(gw), 32'hC3E1);
    endtask

    task automatic t_false_marker();
        logic lk, er, gc; int nv; logic [15:0] gw;
        int vtot;
        do_reset();
        put(2'b00);               // false marker, slot now one symbol early
        vtot = 0;
        // last data symbol 01 lands in the marker slot -> slip back onto true marker
        rx_group(16'hF0F1, 2'b11, lk, er, nv, gw, gc);
        vtot += nv;
        check("R9 no lock on false", 32'(rx_locked), 0);
        for (int g = 0; g < 3; g++) begin
            rx_group(16'h4D2B, 2'b00, lk, er, nv, gw, gc);
            vtot += nv;
            check("R9 hunting unlocked", 32'(lk), 0);
        end
        check("R6 no word while hunting", 32'(vtot), 0);
        rx_group(16'h8E17, 2'b11, lk, er, nv, gw, gc);
        check("R9 locked on true slot", 32'(lk), 1);
        check("R9 aligned word", 32'(gw), 32'h8E17);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_tx();
        t_acquire();
        t_single_err();
        t_drop_relock();
        t_false_marker();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule